// File: doc/BRIEF.md
# Register Port Address-Window Interconnect

This block sits between one register-bus master and a set of register targets. The master drives a request made of an address, write data and single-cycle read and write strobes. The block passes that request to every target. Each target owns a fixed, compile-time window of the address space, described by a base and a span. A target sees its strobes only when the request address falls inside its window. Every target always receives the address minus its own base, so target logic decodes small local offsets.

On the return path, each target drives read data, a single-cycle data-valid pulse and a ready flag. The block merges these into one response. Read data and data-valid are the bitwise OR of the target values. Ready is the AND of the target ready flags. An idle target drives zero data, valid low and ready high, so it has no effect on the merge. The merge adds no register, so the master sees each target's response in the same cycle the target drives it.

Both master-side ports are flat bit vectors with a fixed field layout. This lets the block be wired through hierarchy that carries only plain vectors. The clock and reset inputs feed only the embedded protocol checks.

Top module: `regport_window_xbar`

## Requirements
- R1: Target i is strobed only when base_i <= address < base_i + span_i. An address equal to base_i + span_i does not select target i. Windows do not overlap, so at most one target receives a read strobe and at most one a write strobe in any cycle.
- R2: Every target receives (address - base_i) modulo 2^16 on its address output in every cycle, whether or not the address is in its window.
- R3: Every target receives the request write data unchanged in every cycle, whether or not the address is in its window.
- R4: When the address lies in no window, no target receives any strobe. A read strobe reaches a target only as a read strobe and a write strobe only as a write strobe.
- R5: Merged read data is the bitwise OR of all target read data. Merged data-valid is the OR of all target data-valid flags.
- R6: Merged ready is the AND of all target ready flags. When all targets are idle (data 0, valid 0, ready 1), the flat response equals 34'h1.
- R7: The 50-bit flat request places the write strobe at bit 0, the read strobe at bit 1, write data at bits 33:2 and the address at bits 49:34.
- R8: The 34-bit flat response places ready at bit 0, data-valid at bit 1 and read data at bits 33:2.
- R9: Target strobes, rebased addresses and the merged response are combinational. They change in the same cycle as the inputs that cause them, with no added latency.
- R10: Request strobes and merged data-valid are single-cycle pulses. A strobe is low in the cycle after the one in which it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded protocol checks |
| rst_n | input | 1 | Active-low reset that disables the checks |
| req_flat_i | input | 50 | Flat master request: {address, write data, read strobe, write strobe} |
| rsp_flat_o | output | 34 | Flat merged response: {read data, data-valid, ready} |
| tgt_addr_o | output | 16*NUM_TGT | Rebased address per target; target i at bits [16i +: 16] |
| tgt_wdata_o | output | 32*NUM_TGT | Write data per target; target i at bits [32i +: 32] |
| tgt_rd_o | output | NUM_TGT | Window-qualified read strobe per target |
| tgt_wr_o | output | NUM_TGT | Window-qualified write strobe per target |
| tgt_rdata_i | input | 32*NUM_TGT | Read data from each target; target i at bits [32i +: 32] |
| tgt_rvalid_i | input | NUM_TGT | Data-valid pulse from each target |
| tgt_ready_i | input | NUM_TGT | Ready flag from each target |

## Verification
The assertions check three properties on every clock cycle:
- At most one target is strobed at a time.
- A forwarded strobe always carries a rebased address below that target's span.
- Request strobes and merged data-valid stay single-cycle.

Only the bench scenarios can show the exact values:
- The window boundaries, including the address one past each window's end and addresses in the unmapped gap.
- Address wraparound for targets whose base is above the request address.
- The OR/AND merge with several targets responding at once.
- The placement of every field in the two flat vectors.

// File: rtl/regport_pkg.sv
`timescale 1ns/1ps
package regport_pkg;

    localparam int unsigned RP_ADDR_W     = 16;
    localparam int unsigned RP_DATA_W     = 32;
    localparam int unsigned RP_REQ_FLAT_W = RP_ADDR_W + RP_DATA_W + 2;
    localparam int unsigned RP_RSP_FLAT_W = RP_DATA_W + 2;

    typedef struct packed {
        logic [RP_ADDR_W-1:0] addr;
        logic [RP_DATA_W-1:0] wdata;
        logic                 rd;
        logic                 wr;
    } rp_req_t;

    typedef struct packed {
        logic [RP_DATA_W-1:0] rdata;
        logic                 valid;
        logic                 ready;
    } rp_rsp_t;

    // Flat request: wr at bit 0, rd at bit 1, data above, address on top
    function automatic rp_req_t req_from_flat(input logic [RP_REQ_FLAT_W-1:0] v);
        rp_req_t r;
        r.wr    = v[0];
        r.rd    = v[1];
        r.wdata = v[2 +: RP_DATA_W];
        r.addr  = v[2 + RP_DATA_W +: RP_ADDR_W];
        return r;
    endfunction

    function automatic logic [RP_REQ_FLAT_W-1:0] req_to_flat(input rp_req_t r);
        logic [RP_REQ_FLAT_W-1:0] v;
        v[0]                        = r.wr;
        v[1]                        = r.rd;
        v[2 +: RP_DATA_W]           = r.wdata;
        v[2 + RP_DATA_W +: RP_ADDR_W] = r.addr;
        return v;
    endfunction

    // Flat response: ready at bit 0, valid at bit 1, data above
    function automatic logic [RP_RSP_FLAT_W-1:0] rsp_to_flat(input rp_rsp_t s);
        logic [RP_RSP_FLAT_W-1:0] v;
        v[0]              = s.ready;
        v[1]              = s.valid;
        v[2 +: RP_DATA_W] = s.rdata;
        return v;
    endfunction

    function automatic rp_rsp_t rsp_from_flat(input logic [RP_RSP_FLAT_W-1:0] v);
        rp_rsp_t s;
        s.ready = v[0];
        s.valid = v[1];
        s.rdata = v[2 +: RP_DATA_W];
        return s;
    endfunction

endpackage

// File: rtl/rp_flat_io.sv
`timescale 1ns/1ps
module rp_flat_io
    import regport_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [RP_REQ_FLAT_W-1:0] req_flat_i,
    output rp_req_t                  req_o,
    input  rp_rsp_t                  rsp_i,
    output logic [RP_RSP_FLAT_W-1:0] rsp_flat_o
);

    rp_req_t                  req_d;
    logic [RP_RSP_FLAT_W-1:0] rsp_flat_d;

    always_comb begin
        req_d      = req_from_flat(req_flat_i);
        rsp_flat_d = rsp_to_flat(rsp_i);
    end

    assign req_o      = req_d;
    assign rsp_flat_o = rsp_flat_d;

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_o.rd |=> !req_o.rd); // R10
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_o.wr |=> !req_o.wr); // R10

endmodule

// File: rtl/rp_window_gate.sv
`timescale 1ns/1ps
module rp_window_gate
    import regport_pkg::*;
#(
    parameter logic [RP_ADDR_W-1:0] BASE = '0,
    parameter logic [RP_ADDR_W-1:0] SPAN = 16'h0010
) (
    input  logic    clk,
    input  logic    rst_n,
    input  rp_req_t req_i,
    output rp_req_t req_o
);

    // Exclusive upper bound, one bit wider so a window ending at the top of
    // the address space does not wrap
    localparam logic [RP_ADDR_W:0] LIMIT = {1'b0, BASE} + {1'b0, SPAN};

    rp_req_t gate_d;
    logic    lo_ok;
    logic    hi_ok;
    logic    hit;

    always_comb begin
        lo_ok        = (req_i.addr >= BASE);
        hi_ok        = ({1'b0, req_i.addr} < LIMIT);
        hit          = lo_ok && hi_ok;
        gate_d.addr  = req_i.addr - BASE;
        gate_d.wdata = req_i.wdata;
        gate_d.rd    = req_i.rd && hit;
        gate_d.wr    = req_i.wr && hit;
    end

    assign req_o = gate_d;

    AST_STROBE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o.rd || req_o.wr) |-> ({1'b0, req_o.addr} < {1'b0, SPAN})); // R1
    AST_RD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        req_o.rd |-> req_i.rd); // R4
    AST_WR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        req_o.wr |-> req_i.wr); // R4

endmodule

// File: rtl/rp_resp_merge.sv
`timescale 1ns/1ps
module rp_resp_merge
    import regport_pkg::*;
#(
    parameter int unsigned NUM_TGT = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_TGT*RP_DATA_W-1:0]   rdata_i,
    input  logic [NUM_TGT-1:0]             valid_i,
    input  logic [NUM_TGT-1:0]             ready_i,
    output rp_rsp_t                        rsp_o
);

    rp_rsp_t merge_d;

    always_comb begin
        merge_d.rdata = '0;
        merge_d.valid = 1'b0;
        merge_d.ready = 1'b1;
        for (int i = 0; i < NUM_TGT; i++) begin
            merge_d.rdata = merge_d.rdata | rdata_i[i*RP_DATA_W +: RP_DATA_W];
            merge_d.valid = merge_d.valid | valid_i[i];
            merge_d.ready = merge_d.ready & ready_i[i];
        end
    end

    assign rsp_o = merge_d;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_o.valid |=> !rsp_o.valid); // R10

endmodule

// File: rtl/regport_window_xbar.sv
`timescale 1ns/1ps
module regport_window_xbar
    import regport_pkg::*;
#(
    parameter int unsigned                   NUM_TGT  = 3,
    parameter logic [NUM_TGT*RP_ADDR_W-1:0]  TGT_BASE = {16'h0040, 16'h0010, 16'h0000},
    parameter logic [NUM_TGT*RP_ADDR_W-1:0]  TGT_SPAN = {16'h0008, 16'h0020, 16'h0010}
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [RP_REQ_FLAT_W-1:0]       req_flat_i,
    output logic [RP_RSP_FLAT_W-1:0]       rsp_flat_o,
    output logic [NUM_TGT*RP_ADDR_W-1:0]   tgt_addr_o,
    output logic [NUM_TGT*RP_DATA_W-1:0]   tgt_wdata_o,
    output logic [NUM_TGT-1:0]             tgt_rd_o,
    output logic [NUM_TGT-1:0]             tgt_wr_o,
    input  logic [NUM_TGT*RP_DATA_W-1:0]   tgt_rdata_i,
    input  logic [NUM_TGT-1:0]             tgt_rvalid_i,
    input  logic [NUM_TGT-1:0]             tgt_ready_i
);

    rp_req_t req_q_in;
    rp_rsp_t rsp_merged;
    rp_req_t gated [NUM_TGT];

    rp_flat_io u_flat (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_flat_i (req_flat_i),
        .req_o      (req_q_in),
        .rsp_i      (rsp_merged),
        .rsp_flat_o (rsp_flat_o)
    );

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
        rp_window_gate #(
            .BASE (TGT_BASE[g*RP_ADDR_W +: RP_ADDR_W]),
            .SPAN (TGT_SPAN[g*RP_ADDR_W +: RP_ADDR_W])
        ) u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .req_i (req_q_in),
            .req_o (gated[g])
        );
        assign tgt_addr_o[g*RP_ADDR_W +: RP_ADDR_W]  = gated[g].addr;
        assign tgt_wdata_o[g*RP_DATA_W +: RP_DATA_W] = gated[g].wdata;
        assign tgt_rd_o[g]                           = gated[g].rd;
        assign tgt_wr_o[g]                           = gated[g].wr;
    end

    rp_resp_merge #(
        .NUM_TGT (NUM_TGT)
    ) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .rdata_i (tgt_rdata_i),
        .valid_i (tgt_rvalid_i),
        .ready_i (tgt_ready_i),
        .rsp_o   (rsp_merged)
    );

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_rd_o) && $onehot0(tgt_wr_o)); // R1
    AST_NO_RD_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_flat_i[1] |-> (tgt_rd_o == '0)); // R4
    AST_NO_WR_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_flat_i[0] |-> (tgt_wr_o == '0)); // R4

endmodule

// File: tb/tb_regport_window_xbar.sv
`timescale 1ns/1ps
module tb_regport_window_xbar;

    localparam int NT = 3;
    localparam int BASE [NT] = '{32'h0000, 32'h0010, 32'h0040};
    localparam int SPAN [NT] = '{32'h0010, 32'h0020, 32'h0008};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [49:0]      req_flat_i = '0;
    logic [33:0]      rsp_flat_o;
    logic [NT*16-1:0] tgt_addr_o;
    logic [NT*32-1:0] tgt_wdata_o;
    logic [NT-1:0]    tgt_rd_o;
    logic [NT-1:0]    tgt_wr_o;
    logic [NT*32-1:0] tgt_rdata_i = '0;
    logic [NT-1:0]    tgt_rvalid_i = '0;
    logic [NT-1:0]    tgt_ready_i = '1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    regport_window_xbar dut (
        .clk(clk), .rst_n(rst_n), .req_flat_i(req_flat_i), .rsp_flat_o(rsp_flat_o),
        .tgt_addr_o(tgt_addr_o), .tgt_wdata_o(tgt_wdata_o), .tgt_rd_o(tgt_rd_o),
        .tgt_wr_o(tgt_wr_o), .tgt_rdata_i(tgt_rdata_i), .tgt_rvalid_i(tgt_rvalid_i),
        .tgt_ready_i(tgt_ready_i)
    );

    function automatic int exp_sel(input logic [15:0] a);
        for (int i = 0; i < NT; i++)
            if (int'(a) >= BASE[i] && int'(a) < BASE[i] + SPAN[i]) return i;
        return -1;
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        req_flat_i   = '0;
        tgt_rdata_i  = '0;
        tgt_rvalid_i = '0;
        tgt_ready_i  = '1;
    endtask

    // One strobe cycle, checked combinationally, then one idle cycle
    task automatic step(input logic [15:0] a, input logic [31:0] d, input bit rd, input bit wr,
                        input logic [NT*32-1:0] rdat, input logic [NT-1:0] vld,
                        input logic [NT-1:0] rdy);
        int sel;
        logic [31:0] ed;
        @(negedge clk);
        req_flat_i   = {a, d, rd, wr}; // R7 layout
        tgt_rdata_i  = rdat;
        tgt_rvalid_i = vld;
        tgt_ready_i  = rdy;
        #1;
        sel = exp_sel(a);
        for (int i = 0; i < NT; i++) begin
            chk(sel < 0 ? "R4 rd unmapped" : "R1 rd window", 64'(tgt_rd_o[i]), 64'(rd && sel == i));
            chk(sel < 0 ? "R4 wr unmapped" : "R1 wr window", 64'(tgt_wr_o[i]), 64'(wr && sel == i));
            chk("R2/R7 rebased addr", 64'(tgt_addr_o[i*16 +: 16]), 64'(16'(a - 16'(BASE[i]))));
            chk("R3/R7 wdata", 64'(tgt_wdata_o[i*32 +: 32]), 64'(d));
        end
        ed = '0;
        for (int i = 0; i < NT; i++) ed |= rdat[i*32 +: 32];
        chk("R5/R8/R9 rdata", 64'(rsp_flat_o[33:2]), 64'(ed));
        chk("R5/R8 valid", 64'(rsp_flat_o[1]), 64'(|vld));
        chk("R6/R8 ready", 64'(rsp_flat_o[0]), 64'(&rdy));
        @(negedge clk);
        idle();
        #1;
        chk("R10 strobes low after pulse", 64'({tgt_rd_o, tgt_wr_o}), 64'(0));
    endtask

    initial begin
        void'($urandom(32'd2024));
        idle();
        repeat (3) @(negedge clk);
        #1;
        chk("R6 idle response", 64'(rsp_flat_o), 64'(34'h1));
        chk("R4 no strobes in reset", 64'({tgt_rd_o, tgt_wr_o}), 64'(0));
        @(negedge clk);
        rst_n = 1'b1;

        // Window edges (R1), unmapped gap and top (R4), wrap (R2)
        step(16'h000F, 32'h11111111, 1, 0, '0, '0, '1);
        step(16'h0010, 32'h22222222, 1, 0, '0, '0, '1);
        step(16'h002F, 32'h33333333, 0, 1, '0, '0, '1);
        step(16'h0030, 32'h44444444, 1, 0, '0, '0, '1);
        step(16'h0047, 32'h55555555, 0, 1, '0, '0, '1);
        step(16'h0048, 32'h66666666, 0, 1, '0, '0, '1);
        step(16'hFFFF, 32'h77777777, 1, 0, '0, '0, '1);
        step(16'h0000, 32'h88888888, 0, 1, '0, '0, '1);
        // Merge: OR of two data words, one valid, one target busy (R5, R6)
        step(16'h0004, 32'h0, 1, 0, {32'h0, 32'h0000FF00, 32'h00F0000F}, 3'b001, 3'b111);
        step(16'h0030, 32'h0, 0, 0, {32'hA0000000, 32'h0, 32'h0}, 3'b100, 3'b101);
        step(16'h0030, 32'h0, 0, 0, '0, '0, 3'b000);

        for (int n = 0; n < 400; n++) begin
            logic [15:0] a;
            int k;
            logic [NT*32-1:0] rd_v;
            logic [NT-1:0] vv, rr;
            k = int'($urandom % NT);
            case ($urandom % 3)
                0: a = 16'($urandom);
                1: a = 16'(BASE[k] + SPAN[k] - int'($urandom % 2));
                default: a = 16'($urandom % 32'h50);
            endcase
            rd_v = {$urandom, $urandom, $urandom};
            vv = 3'($urandom);
            for (int i = 0; i < NT; i++) rr[i] = ($urandom % 4) != 0;
            case ($urandom % 3)
                0: step(a, $urandom, 1, 0, rd_v, vv, rr);
                1: step(a, $urandom, 0, 1, rd_v, vv, rr);
                default: step(a, $urandom, 0, 0, rd_v, vv, rr);
            endcase
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired, run incomplete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule